// File: doc/BRIEF.md
# Configurable UART Transmit Framer

This block turns one parallel character into one asynchronous serial frame on a single output line. A character is offered with a valid/ready handshake. At the moment it is accepted, the block also samples its format inputs: the word length (5 to 8 bits), parity on or off, even or odd parity, and the stop-bit control. The frame is then shifted out in this order: a low start bit, the data bits least significant first, an optional parity bit, and a high stop period.

All bit timing comes from a baud tick at sixteen times the bit rate. Each bit lasts a fixed number of ticks, and the ticks are counted in a single counter. A stop period may therefore be one and a half bit times long. This half-bit length applies only to 5-bit characters when the stop control is set. With the stop control set, 6-, 7- and 8-bit characters get two full stop bits.

When no character is being sent, the line rests high and the block is ready for the next character. While a frame is in progress, ready is held low and a busy flag is high.

Top module: `uart_tx_framer`

## Requirements
- R1: After a synchronous reset, `txd` is 1, `in_ready` is 1 and `busy` is 0.
- R2: A character is accepted on a clock edge where `in_valid` and `in_ready` are both 1. From the next cycle, `in_ready` is 0 and `busy` is 1 until the edge that completes the last stop tick. `in_valid` has no effect while `in_ready` is 0.
- R3: The cycle after acceptance, `txd` goes to 0. It stays there for 16 ticks of `tick16` (the start bit).
- R4: `cfg_wlen` code 00, 01, 10 or 11 selects 5, 6, 7 or 8 data bits. The data bits are sent bit 0 first, each for 16 ticks. Bits of `in_data` above the selected length are never sent.
- R5: When `cfg_par_en` is 1, one parity bit of 16 ticks follows the last data bit. With `cfg_par_odd` = 0 the count of ones over the data bits and the parity bit is even; with 1 it is odd. When `cfg_par_en` is 0, no parity bit is sent.
- R6: When `cfg_stop_long` is 0, the stop period is high for 16 ticks, whatever the word length.
- R7: When `cfg_stop_long` is 1, the stop period lasts 24 ticks for `cfg_wlen` = 00 and 32 ticks for every other word length.
- R8: The format inputs are sampled only at acceptance. Changing them during a frame does not change that frame.
- R9: `txd` changes only on the edge after a `tick16` pulse or on the edge after acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Block can accept a character |
| in_data | input | 8 | Character; low-order bits are sent |
| cfg_wlen | input | 2 | Word length code (5 + code bits) |
| cfg_stop_long | input | 1 | Long stop period select |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| txd | output | 1 | Serial line, idle high |
| busy | output | 1 | Frame in progress |

## Verification
Some properties are checked by assertions on every cycle:
- the reset state;
- ready dropping and the line going low right after acceptance;
- the line holding steady unless a tick or an acceptance came first;
- busy ending only on a tick.

Other behaviour can only be shown by the bench scenarios, which compare the line against a per-tick model:
- the exact length of each bit and stop period;
- the order of the data bits;
- the parity values;
- the 24- versus 32-tick stop choice;
- the fact that a format change made during a frame is ignored.

// File: rtl/utx_pkg.sv
package utx_pkg;

    localparam int unsigned CHAR_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    typedef enum logic [1:0] {
        STOP_ONE,
        STOP_ONE_HALF,
        STOP_TWO
    } stop_len_e;

    typedef struct packed {
        logic [3:0] nbits;
        logic       par_en;
        logic       par_bit;
        stop_len_e  stop_len;
    } frame_fmt_t;

    function automatic logic [3:0] word_bits(input logic [1:0] code);
        return 4'(5 + int'(code));
    endfunction

    function automatic stop_len_e pick_stop(input logic [1:0] code, input logic long_sel);
        if (!long_sel)
            return STOP_ONE;
        else if (code == 2'b00)
            return STOP_ONE_HALF;
        else
            return STOP_TWO;
    endfunction

    function automatic logic parity_of(input logic [CHAR_W-1:0] d,
                                       input logic [3:0] nbits,
                                       input logic odd);
        logic acc;
        acc = odd;
        for (int i = 0; i < CHAR_W; i++)
            if (i < int'(nbits))
                acc = acc ^ d[i];
        return acc;
    endfunction

endpackage

// File: rtl/utx_fmt_latch.sv
module utx_fmt_latch
    import utx_pkg::*;
#(
    parameter int unsigned DATA_W = CHAR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] data_in,
    input  logic [1:0]        wlen,
    input  logic              stop_long,
    input  logic              par_en,
    input  logic              par_odd,
    output frame_fmt_t        fmt,
    output logic [DATA_W-1:0] data_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            fmt    <= '{nbits: 4'd8, par_en: 1'b0, par_bit: 1'b0, stop_len: STOP_ONE};
            data_q <= '0;
        end else if (load) begin
            fmt.nbits    <= word_bits(wlen);
            fmt.par_en   <= par_en;
            fmt.par_bit  <= parity_of(data_in, word_bits(wlen), par_odd);
            fmt.stop_len <= pick_stop(wlen, stop_long);
            data_q       <= data_in;
        end
    end

endmodule

// File: rtl/utx_bit_timer.sv
module utx_bit_timer #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             bit_done
);

    logic [CNT_W-1:0] cnt;

    assign bit_done = run && tick && (cnt == limit - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (bit_done)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + CNT_W'(1);
    end

endmodule

// File: rtl/utx_seq.sv
module utx_seq
    import utx_pkg::*;
#(
    parameter int unsigned OVS    = 16,
    parameter int unsigned CNT_W  = 6,
    parameter int unsigned DATA_W = CHAR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              bit_done,
    input  frame_fmt_t        fmt,
    input  logic [DATA_W-1:0] data,
    output logic [CNT_W-1:0]  limit,
    output logic              txd,
    output logic              busy
);

    localparam int unsigned IDX_W = $clog2(DATA_W);

    tx_state_e        state;
    logic [IDX_W-1:0] idx;
    logic             last_data;

    assign last_data = (idx == IDX_W'(fmt.nbits - 4'd1));
    assign busy      = (state != ST_IDLE);

    always_comb begin
        limit = CNT_W'(OVS);
        if (state == ST_STOP) begin
            case (fmt.stop_len)
                STOP_ONE_HALF: limit = CNT_W'(OVS + OVS / 2);
                STOP_TWO:      limit = CNT_W'(2 * OVS);
                default:       limit = CNT_W'(OVS);
            endcase
        end
    end

    always_comb begin
        case (state)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = data[idx];
            ST_PAR:   txd = fmt.par_bit;
            default:  txd = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (load) state <= ST_START;
                ST_START: if (bit_done) begin
                    state <= ST_DATA;
                    idx   <= '0;
                end
                ST_DATA: if (bit_done) begin
                    if (last_data)
                        state <= fmt.par_en ? ST_PAR : ST_STOP;
                    else
                        idx <= idx + IDX_W'(1);
                end
                ST_PAR:  if (bit_done) state <= ST_STOP;
                ST_STOP: if (bit_done) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
    import utx_pkg::*;
#(
    parameter int unsigned OVS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CHAR_W-1:0] in_data,
    input  logic [1:0]        cfg_wlen,
    input  logic              cfg_stop_long,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              tick16,
    output logic              txd,
    output logic              busy
);

    localparam int unsigned CNT_W = $clog2(2 * OVS + 1);

    frame_fmt_t        fmt;
    logic [CHAR_W-1:0] data_q;
    logic [CNT_W-1:0]  limit;
    logic              load;
    logic              bit_done;

    assign in_ready = !busy;
    assign load     = in_valid && in_ready;

    utx_fmt_latch #(.DATA_W(CHAR_W)) u_fmt (
        .clk(clk), .rst(rst), .load(load), .data_in(in_data),
        .wlen(cfg_wlen), .stop_long(cfg_stop_long),
        .par_en(cfg_par_en), .par_odd(cfg_par_odd),
        .fmt(fmt), .data_q(data_q)
    );

    utx_bit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .run(busy), .tick(tick16),
        .limit(limit), .bit_done(bit_done)
    );

    utx_seq #(.OVS(OVS), .CNT_W(CNT_W), .DATA_W(CHAR_W)) u_seq (
        .clk(clk), .rst(rst), .load(load), .bit_done(bit_done),
        .fmt(fmt), .data(data_q), .limit(limit), .txd(txd), .busy(busy)
    );

endmodule

// File: rtl/utx_checker.sv
module utx_checker (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_ready,
    input logic tick16,
    input logic txd,
    input logic busy
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (txd && in_ready && !busy));

    // R2
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (!in_ready && busy));

    // R3
    start_low_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !txd);

    // R9
    line_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick16 && !(in_valid && in_ready)) |=> $stable(txd));

    // R2
    end_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(tick16));

endmodule

bind uart_tx_framer utx_checker u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .tick16(tick16), .txd(txd), .busy(busy)
);

// File: tb/sim_uart_tx_framer.sv
module sim_uart_tx_framer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic [1:0] cfg_wlen = 2'b11;
    logic       cfg_stop_long = 1'b0;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       tick16 = 1'b0;
    logic       in_ready, txd, busy;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uart_tx_framer u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .cfg_wlen(cfg_wlen), .cfg_stop_long(cfg_stop_long),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .tick16(tick16), .txd(txd), .busy(busy)
    );

    // Reference model: queue of line segments (level, length in ticks, requirement)
    bit    q_lvl[$];
    int    q_len[$];
    string q_req[$];
    int    m_cnt = 0;

    task automatic push_seg(input bit lvl, input int len, input string req);
        q_lvl.push_back(lvl);
        q_len.push_back(len);
        q_req.push_back(req);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            q_lvl.delete(); q_len.delete(); q_req.delete();
            m_cnt = 0;
        end else if (q_lvl.size() == 0) begin
            if (in_valid) begin
                int nb;
                int ones;
                nb = 5 + int'(cfg_wlen);
                ones = 0;
                push_seg(1'b0, 16, "R3");
                for (int i = 0; i < nb; i++) begin
                    push_seg(in_data[i], 16, "R4");
                    ones += int'(in_data[i]);
                end
                if (cfg_par_en)
                    push_seg(bit'((ones % 2) ^ int'(cfg_par_odd)), 16, "R5");
                if (!cfg_stop_long)
                    push_seg(1'b1, 16, "R6");
                else
                    push_seg(1'b1, (cfg_wlen == 2'b00) ? 24 : 32, "R7");
                m_cnt = 0;
            end
        end else if (tick16) begin
            m_cnt++;
            if (m_cnt == q_len[0]) begin
                void'(q_lvl.pop_front());
                void'(q_len.pop_front());
                void'(q_req.pop_front());
                m_cnt = 0;
            end
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit    e_txd;
            bit    e_rdy;
            string rq;
            e_rdy = (q_lvl.size() == 0);
            e_txd = e_rdy ? 1'b1 : q_lvl[0];
            rq    = e_rdy ? "R2" : q_req[0];
            n_vec++;
            if (txd !== e_txd) begin
                n_bad++;
                $display("FAIL %s txd cycle %0d: got %b expected %b", rq, cyc, txd, e_txd);
            end
            if (in_ready !== e_rdy || busy !== !e_rdy) begin
                n_bad++;
                $display("FAIL R2 handshake cycle %0d: got ready=%b busy=%b expected ready=%b busy=%b",
                         cyc, in_ready, busy, e_rdy, !e_rdy);
            end
        end
    end

    // Baud tick: mostly every 3 cycles, with irregular gaps (R9)
    always @(negedge clk) begin
        tick16 <= ((cyc % 3) == 0) && ((cyc % 41) != 7);
    end

    task automatic send(input logic [7:0] d, input logic [1:0] wl, input bit sl,
                        input bit pe, input bit po, input bit scramble);
        while (!in_ready) @(negedge clk);
        in_valid      = 1'b1;
        in_data       = d;
        cfg_wlen      = wl;
        cfg_stop_long = sl;
        cfg_par_en    = pe;
        cfg_par_odd   = po;
        @(negedge clk);
        in_valid = 1'b0;
        if (scramble) begin
            // R8: change every format input mid-frame
            repeat (20) @(negedge clk);
            in_data       = ~d;
            cfg_wlen      = ~wl;
            cfg_stop_long = !sl;
            cfg_par_en    = !pe;
            cfg_par_odd   = !po;
        end
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        n_vec++;
        if (txd !== 1'b1 || in_ready !== 1'b1 || busy !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: got txd=%b ready=%b busy=%b expected 1 1 0", txd, in_ready, busy);
        end
        // R4: each word length, upper bits must not be sent
        send(8'hFF, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0); wait_idle();
        send(8'hA5, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0); wait_idle();
        send(8'h3C, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0); wait_idle();
        send(8'h96, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0); wait_idle();
        // R5: even and odd parity, various widths
        send(8'h01, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0); wait_idle();
        send(8'h01, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0); wait_idle();
        send(8'hE0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0); wait_idle();
        send(8'h00, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0); wait_idle();
        // R7: long stop, 1.5 for 5-bit and 2 for others
        send(8'h15, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0); wait_idle();
        send(8'h2A, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0); wait_idle();
        send(8'h7F, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0); wait_idle();
        // R6: short stop with 5-bit and parity
        send(8'h0B, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0); wait_idle();
        // R8: format scrambled during a frame
        send(8'h5A, 2'b10, 1'b1, 1'b1, 1'b0, 1'b1); wait_idle();
        send(8'hC3, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1); wait_idle();
        // R2: back-to-back frames, then valid held while busy is ignored
        send(8'h81, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
        send(8'h42, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0);
        repeat (10) @(negedge clk);
        in_valid = 1'b1;
        in_data  = 8'hEE;
        repeat (30) @(negedge clk);
        in_valid = 1'b0;
        wait_idle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule